// File: doc/BRIEF.md
# Nibble-Serial Header Check Generator

This block computes the 16-bit check value that guards the headers of serial-bus configuration and map blocks. A caller first pulses `start` with the number of 32-bit quadlets the block covers. It then offers the quadlets one at a time on a valid/ready handshake. Each accepted quadlet is folded into a 16-bit accumulator four bits per clock, beginning with the most significant nibble. One quadlet therefore occupies the engine for eight cycles, and the input is not ready during that time.

When the final nibble of the final quadlet has been folded in, `done` pulses for one cycle. `crc` then holds the result. `header` holds a ready-made header quadlet: the covered length in quadlets sits in the upper half and the check value in the lower half. Both outputs keep their values until the next accepted start. Quadlets are taken in big-endian order exactly as presented, and the block does not store them.

Top module: `nibble_crc16`

## Requirements
- R1: While `rst` is high and after it falls, `done` and `in_ready` are 0 and `crc` and `header` read 0.
- R2: A `start` seen while idle with a nonzero `count` raises `in_ready` in the next cycle. A quadlet is taken on a clock edge where `in_valid` and `in_ready` are both 1, and `in_ready` stays 1 through cycles where `in_valid` is 0.
- R3: After a quadlet is taken, `in_ready` stays 0 for exactly eight cycles, one for each nibble step. It returns to 1 after the eighth step when more quadlets remain.
- R4: Each nibble n, taken from bits 31:28 down to bits 3:0, updates the accumulator c as follows: s = c[15:12] xor n, then c = ((c << 4) xor (s << 12) xor (s << 5) xor s) mod 2^16. As examples, the single quadlet 0x00000001 gives 0x1021 and 0x00000010 gives 0x1231.
- R5: The accumulator is cleared to 0 by every accepted start, so a result never depends on earlier blocks.
- R6: `done` is 1 for one cycle, in the cycle after the eighth nibble step of the last quadlet, and is 0 at all other times.
- R7: A start with `count` equal to 0 gives `done` = 1 in the next cycle with `crc` = 0x0000, and never raises `in_ready`.
- R8: `header` equals the latched count in bits 31:16 and `crc` in bits 15:0.
- R9: A `start` pulse that arrives while a block is in progress is ignored. The running block's result and its header length are unchanged.
- R10: After `done`, `crc` and `header` hold their values until the next accepted start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Begin a new block (accepted only when idle) |
| count | input | 16 | Number of quadlets in the block, sampled with `start` |
| in_valid | input | 1 | Quadlet on `in_data` is valid |
| in_data | input | 32 | Quadlet, big-endian, bits 31:28 folded first |
| in_ready | output | 1 | Block can take a quadlet this cycle |
| done | output | 1 | One-cycle pulse when the check value is final |
| crc | output | 16 | Accumulated check value |
| header | output | 32 | Length in bits 31:16, check value in bits 15:0 |

## Verification
The bench builds the block with the package defaults: 32-bit quadlets, 4-bit nibbles, a 16-bit accumulator and a 16-bit length field. These widths give eight steps per quadlet and a full-width header, so the bench can measure the eight-cycle ready gap exactly. The 16-bit length field lets it place count zero and multi-quadlet counts side by side. With a 16-bit accumulator, results for all-ones, top-bit-only and mixed-pattern quadlets bring every feedback tap into play. Idle gaps on `in_valid`, a start pulse injected mid-block, and back-to-back blocks cover the handshake edges and the clearing between blocks.

// File: rtl/nibcrc_pkg.sv
package nibcrc_pkg;

    localparam int QUAD_W  = 32;
    localparam int NIB_W   = 4;
    localparam int CRC_W   = 16;
    localparam int LEN_W   = 16;
    localparam int NIBS    = QUAD_W / NIB_W;
    localparam int IDX_W   = $clog2(NIBS);
    localparam int TAP_HI  = 12;
    localparam int TAP_MID = 5;
    localparam int HDR_W   = LEN_W + CRC_W;

    typedef logic [CRC_W-1:0]  crc_t;
    typedef logic [QUAD_W-1:0] quad_t;
    typedef logic [NIB_W-1:0]  nib_t;
    typedef logic [LEN_W-1:0]  len_t;
    typedef logic [IDX_W-1:0]  idx_t;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_WAIT = 2'd1,
        ST_STEP = 2'd2
    } state_e;

    typedef struct packed {
        len_t len;
        crc_t chk;
    } header_t;

    // One nibble of the shift/xor feedback; bits above CRC_W fall away.
    function automatic crc_t nib_step(crc_t acc, nib_t nib);
        nib_t s;
        crc_t fb;
        s  = acc[CRC_W-1 -: NIB_W] ^ nib;
        fb = (crc_t'(s) << TAP_HI) ^ (crc_t'(s) << TAP_MID) ^ crc_t'(s);
        return (acc << NIB_W) ^ fb;
    endfunction

    function automatic header_t pack_header(len_t len, crc_t chk);
        header_t h;
        h.len = len;
        h.chk = chk;
        return h;
    endfunction

endpackage

// File: rtl/nibcrc_ctrl.sv
module nibcrc_ctrl
    import nibcrc_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic start,
    input  len_t count,
    input  logic in_valid,
    output logic in_ready,
    output logic clear,
    output logic load,
    output logic step,
    output logic busy,
    output logic done,
    output len_t len_q
);
    localparam idx_t LAST_NIB = idx_t'(NIBS - 1);

    state_e state;
    len_t   remaining;
    idx_t   idx;
    logic   done_q;

    assign in_ready = (state == ST_WAIT);
    assign clear    = (state == ST_IDLE) && start;
    assign load     = (state == ST_WAIT) && in_valid;
    assign step     = (state == ST_STEP);
    assign busy     = (state != ST_IDLE);
    assign done     = done_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= ST_IDLE;
            remaining <= '0;
            idx       <= '0;
            done_q    <= 1'b0;
            len_q     <= '0;
        end else begin
            done_q <= 1'b0;
            unique case (state)
                ST_IDLE: begin
                    if (start) begin
                        len_q <= count;
                        if (count == '0) begin
                            done_q <= 1'b1;
                        end else begin
                            remaining <= count;
                            state     <= ST_WAIT;
                        end
                    end
                end
                ST_WAIT: begin
                    if (in_valid) begin
                        idx   <= '0;
                        state <= ST_STEP;
                    end
                end
                ST_STEP: begin
                    idx <= idx + idx_t'(1);
                    if (idx == LAST_NIB) begin
                        remaining <= remaining - len_t'(1);
                        if (remaining == len_t'(1)) begin
                            done_q <= 1'b1;
                            state  <= ST_IDLE;
                        end else begin
                            state <= ST_WAIT;
                        end
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/nibcrc_engine.sv
module nibcrc_engine
    import nibcrc_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  clear,
    input  logic  load,
    input  quad_t load_data,
    input  logic  step,
    output crc_t  acc
);
    quad_t qreg;
    crc_t  acc_q;

    assign acc = acc_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            acc_q <= '0;
            qreg  <= '0;
        end else begin
            if (clear) begin
                acc_q <= '0;
            end else if (step) begin
                acc_q <= nib_step(acc_q, qreg[QUAD_W-1 -: NIB_W]);
            end
            if (load) begin
                qreg <= load_data;
            end else if (step) begin
                qreg <= qreg << NIB_W;
            end
        end
    end
endmodule

// File: rtl/nibcrc_hdr.sv
module nibcrc_hdr
    import nibcrc_pkg::*;
(
    input  len_t               len,
    input  crc_t               chk,
    output logic [HDR_W-1:0]   header
);
    header_t h;
    always_comb h = pack_header(len, chk);
    assign header = h;
endmodule

// File: rtl/nibble_crc16.sv
module nibble_crc16
    import nibcrc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [LEN_W-1:0]  count,
    input  logic              in_valid,
    input  logic [QUAD_W-1:0] in_data,
    output logic              in_ready,
    output logic              done,
    output logic [CRC_W-1:0]  crc,
    output logic [HDR_W-1:0]  header
);
    logic clear_w;
    logic load_w;
    logic step_w;
    logic busy_w;
    len_t len_w;
    crc_t acc_w;

    nibcrc_ctrl u_ctrl (
        .clk      (clk),
        .rst      (rst),
        .start    (start),
        .count    (count),
        .in_valid (in_valid),
        .in_ready (in_ready),
        .clear    (clear_w),
        .load     (load_w),
        .step     (step_w),
        .busy     (busy_w),
        .done     (done),
        .len_q    (len_w)
    );

    nibcrc_engine u_engine (
        .clk       (clk),
        .rst       (rst),
        .clear     (clear_w),
        .load      (load_w),
        .load_data (in_data),
        .step      (step_w),
        .acc       (acc_w)
    );

    nibcrc_hdr u_hdr (
        .len    (len_w),
        .chk    (acc_w),
        .header (header)
    );

    assign crc = acc_w;
endmodule

// File: rtl/nibble_crc16_chk.sv
module nibble_crc16_chk
    import nibcrc_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              start,
    input logic              in_valid,
    input logic              in_ready,
    input logic              busy,
    input logic              done,
    input logic [CRC_W-1:0]  crc,
    input logic [HDR_W-1:0]  header
);
    p_ready_needs_busy_r2: assert property (@(posedge clk) disable iff (rst)
        !busy |-> !in_ready);

    p_gap_after_take_r3: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_ready) |=> (!in_ready && busy));

    p_clear_on_start_r5: assert property (@(posedge clk) disable iff (rst)
        (start && !busy) |=> (crc == '0));

    p_done_when_idle_r6: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy);

    p_header_pack_r8: assert property (@(posedge clk) disable iff (rst)
        done |-> (header[CRC_W-1:0] == crc));

    p_start_ignored_r9: assert property (@(posedge clk) disable iff (rst)
        (start && busy) |=> $stable(header[HDR_W-1:CRC_W]));

    p_hold_idle_r10: assert property (@(posedge clk) disable iff (rst)
        (!busy && !start) |=> ($stable(crc) && $stable(header)));
endmodule

bind nibble_crc16 nibble_crc16_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .start    (start),
    .in_valid (in_valid),
    .in_ready (in_ready),
    .busy     (busy_w),
    .done     (done),
    .crc      (crc),
    .header   (header)
);

// File: tb/nibble_crc16_bench.sv
module nibble_crc16_bench;
    localparam int CLK_PERIOD = 10;
    localparam int NTBL = 6;
    localparam logic [31:0] TBL [NTBL] = '{
        32'h00000001, 32'h00000010, 32'h31333934,
        32'hFFFFFFFF, 32'h80000000, 32'hDEADBEEF
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [15:0] count = '0;
    logic        in_valid = 1'b0;
    logic [31:0] in_data = '0;
    logic        in_ready;
    logic        done;
    logic [15:0] crc;
    logic [31:0] header;

    int checks = 0;
    int fails = 0;
    bit finished = 1'b0;
    logic [31:0] blk [16];

    always #(CLK_PERIOD/2) clk = ~clk;

    nibble_crc16 u_nibble_crc16 (
        .clk(clk), .rst(rst), .start(start), .count(count),
        .in_valid(in_valid), .in_data(in_data), .in_ready(in_ready),
        .done(done), .crc(crc), .header(header)
    );

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [15:0] ref_crc(input int n);
        logic [31:0] c = 0;
        logic [31:0] nx;
        logic [31:0] s;
        for (int i = 0; i < n; i++) begin
            nx = c;
            for (int sh = 28; sh >= 0; sh -= 4) begin
                s  = ((nx >> 12) ^ (blk[i] >> sh)) & 32'hF;
                nx = (nx << 4) ^ (s << 12) ^ (s << 5) ^ s;
            end
            c = nx & 32'hFFFF;
        end
        return c[15:0];
    endfunction

    // Runs one block of n quadlets from blk; gap idle cycles before each quadlet.
    // If inject is set, a start pulse is driven during the first nibble steps.
    task automatic run_block(input int n, input int gap, input bit inject, input string tag);
        logic [15:0] exp_crc;
        bit ok;
        exp_crc = ref_crc(n);
        @(negedge clk);
        start = 1'b1; count = 16'(n);
        @(negedge clk);
        start = 1'b0;
        if (n == 0) begin
            chk(done == 1'b1 && crc == 16'h0 && in_ready == 1'b0, "R7 zero count", {done, in_ready, crc}, 32'h00020000);
            return;
        end
        chk(in_ready == 1'b1, {"R2 ready after start ", tag}, {31'b0, in_ready}, 32'h1);
        for (int q = 0; q < n; q++) begin
            ok = 1'b1;
            for (int g = 0; g < gap; g++) begin
                if (in_ready !== 1'b1) ok = 1'b0;
                @(negedge clk);
            end
            chk(ok && in_ready, {"R2 ready held while idle input ", tag}, {31'b0, in_ready}, 32'h1);
            in_valid = 1'b1; in_data = blk[q];
            @(negedge clk);
            in_valid = 1'b0; in_data = 32'hA5A5A5A5;
            ok = 1'b1;
            for (int k = 0; k < 8; k++) begin
                if (in_ready !== 1'b0 || done !== 1'b0) ok = 1'b0;
                if (inject && q == 0 && k == 2) start = 1'b1;
                if (inject && q == 0 && k == 3) start = 1'b0;
                if (k < 7) @(negedge clk);
            end
            chk(ok, {"R3 eight-step gap ", tag}, {31'b0, ok}, 32'h1);
            @(negedge clk);
            if (q < n - 1)
                chk(in_ready == 1'b1 && done == 1'b0, {"R3 ready again ", tag}, {30'b0, done, in_ready}, 32'h1);
        end
        chk(done == 1'b1, {"R6 done pulse ", tag}, {31'b0, done}, 32'h1);
        chk(crc == exp_crc, {"R4 crc value ", tag}, {16'b0, crc}, {16'b0, exp_crc});
        chk(header == {16'(n), exp_crc}, {"R8 header ", tag}, header, {16'(n), exp_crc});
        @(negedge clk);
        chk(done == 1'b0, {"R6 done one cycle ", tag}, {31'b0, done}, 32'h0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(done == 0 && in_ready == 0 && crc == 0 && header == 0, "R1 reset held", {done, in_ready, crc}, 32'h0);
        rst = 1'b0;
        @(negedge clk);
        chk(done == 0 && in_ready == 0 && crc == 0 && header == 0, "R1 after reset", {done, in_ready, crc}, 32'h0);

        // Known hand-worked values
        blk[0] = 32'h00000001;
        run_block(1, 0, 1'b0, "q1");
        chk(crc == 16'h1021, "R4 fixed 0x00000001", {16'b0, crc}, 32'h1021);
        blk[0] = 32'h00000010;
        run_block(1, 1, 1'b0, "q10");
        chk(crc == 16'h1231, "R4 fixed 0x00000010", {16'b0, crc}, 32'h1231);

        // Table walk: single-quadlet blocks
        for (int i = 0; i < NTBL; i++) begin
            blk[0] = TBL[i];
            run_block(1, i % 3, 1'b0, "table");
        end

        // Multi-quadlet block with idle gaps
        for (int i = 0; i < 5; i++) blk[i] = TBL[i] ^ (32'h01010101 * i);
        run_block(5, 2, 1'b0, "multi");

        // R10: hold after done
        begin
            logic [15:0] c0;
            logic [31:0] h0;
            c0 = crc; h0 = header;
            repeat (4) @(negedge clk);
            chk(crc == c0 && header == h0 && done == 0, "R10 hold after done", header, h0);
        end

        // R5: a following block starts from zero
        blk[0] = 32'h00000001;
        run_block(1, 0, 1'b0, "R5 fresh");
        chk(crc == 16'h1021, "R5 cleared between blocks", {16'b0, crc}, 32'h1021);

        // R9: start during a busy block ignored
        for (int i = 0; i < 3; i++) blk[i] = 32'h12345678 + 32'(i);
        run_block(3, 0, 1'b1, "R9 start while busy");

        // R7: zero count
        run_block(0, 0, 1'b0, "zero");
        @(negedge clk);
        chk(header == 32'h0 && in_ready == 0, "R7 header for zero", header, 32'h0);

        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!finished) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=%h expected=%h", 32'h0, 32'h1);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule